// File: doc/BRIEF.md
# Flash Block RAM Overlay Remapper

This unit sits between a processor bus and two on-chip memories, a flash array and a RAM. It lets a fixed 4 KB slice of RAM take the place of one chosen 4 KB flash block. Constant tables that normally live in flash can then be edited in place while code keeps reading them at their flash addresses. One control register, placed at its own bus address, holds an enable bit and a 3-bit block number.

Each bus access is decoded combinationally to the flash, the RAM, the control register or nothing. The unit drives exactly one chip select and translates the address into the chosen memory's local space. Read data comes back one cycle later from whichever source the access chose. A registered select, taken in the access cycle, steers that data. Only the first eight 4 KB flash blocks (0x000000 to 0x007FFF) can be overlaid. The RAM slice stays reachable at its own addresses at all times.

Top module: `ovl_remap`

## Requirements
- R1: After reset the control register holds zero: overlay off, block 0 selected. Reading it returns 0 and, with no request, no chip select is active and bus_rdata is 0.
- R2: With the overlay off, every address below 0x040000 asserts fl_cs, and fl_addr carries address bits [17:0].
- R3: With the overlay on, an address whose bits [23:12] equal the selected block number goes to the RAM. rm_cs is set, fl_cs is clear, and rm_addr is 0x1000 plus address bits [11:0]. The window sits at bus 0xFFA000 inside the RAM region based at 0xFF9000.
- R4: The 3-bit block number k picks flash range k*0x1000 to k*0x1000+0xFFF. Other blocks below 0x8000 still go to flash.
- R5: Flash addresses from 0x008000 to 0x03FFFF always go to flash, whatever the register holds.
- R6: Addresses 0xFF9000 to 0xFFBFFF always reach the RAM with rm_addr equal to the address minus 0xFF9000. The overlay window is therefore reachable both there and at the selected flash block.
- R7: A write follows the same routing as a read. Writes into the overlaid block assert rm_we, not fl_we. Flash writes outside it assert fl_we with the untouched address. Write data passes through on mem_wdata.
- R8: At most one chip select is active. An address mapped to nothing, or an idle cycle, selects no memory and yields bus_rdata 0 in the next cycle.
- R9: The control register sits at 0xFFFF00. A write loads bit 3 as the enable and bits [2:0] as the block number, and ignores the other bits. A read returns {28'b0, enable, block} one cycle later.
- R10: The cycle after a read, bus_rdata equals the data word of the memory chosen in the access cycle. Writes return 0.
- R11: A register write governs the routing of the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| fl_cs | output | 1 | Flash chip select |
| fl_we | output | 1 | Flash write enable |
| fl_addr | output | 18 | Flash local address |
| fl_rdata | input | 32 | Flash read data, one cycle after fl_cs |
| rm_cs | output | 1 | RAM chip select |
| rm_we | output | 1 | RAM write enable |
| rm_addr | output | 14 | RAM local address |
| rm_rdata | input | 32 | RAM read data, one cycle after rm_cs |
| mem_wdata | output | 32 | Write data to both memories |

## Verification
Two functions meet in a single cycle. A register write changes the overlay, and the access in the very next cycle must already be routed by the new value. The bench provokes this with directed register writes followed at once by an access to the newly chosen block, and to the block just released. Random runs interleave register writes with flash, RAM and unmapped traffic at random. Each cycle's chip selects, local addresses and next-cycle read data are judged against a bench model that keeps its own copy of the register.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_RAM   = 2'd2,
    TGT_REG   = 2'd3
  } tgt_e;
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W:0]   wdata,
  output logic             ovl_en,
  output logic [SEL_W-1:0] ovl_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_en  <= 1'b0;
      ovl_sel <= '0;
    end else if (wr_en) begin
      ovl_en  <= wdata[SEL_W];
      ovl_sel <= wdata[SEL_W-1:0];
    end
  end

  assert_reg_reset_R1: assert property (@(posedge clk)
    rst |=> (!ovl_en && ovl_sel == '0))
    else $error("control register not cleared by reset");

  assert_reg_load_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ovl_en == $past(wdata[SEL_W]) && ovl_sel == $past(wdata[SEL_W-1:0])))
    else $error("register write not visible in next cycle");

  assert_reg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ovl_en) && $stable(ovl_sel)))
    else $error("register changed without a write");
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int BLK_W       = 12,
  parameter int NUM_BLKS    = 8,
  parameter int FLASH_BYTES = 32'h40000,
  parameter int RAM_BASE    = 32'hFF9000,
  parameter int RAM_BYTES   = 32'h3000,
  parameter int WIN_BASE    = 32'hFFA000,
  parameter int REG_ADDR    = 32'hFFFF00,
  parameter int FL_AW       = 18,
  parameter int RAM_AW      = 14,
  parameter int SEL_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ovl_en,
  input  logic [SEL_W-1:0]  ovl_sel,
  output tgt_e              tgt,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [RAM_AW-1:0] rm_addr
);
  localparam int PG_W    = ADDR_W - BLK_W;
  localparam int WIN_OFF = WIN_BASE - RAM_BASE;
  localparam logic [ADDR_W-1:0] FL_END_A  = ADDR_W'(FLASH_BYTES);
  localparam logic [ADDR_W-1:0] OVL_END_A = ADDR_W'(NUM_BLKS << BLK_W);
  localparam logic [ADDR_W-1:0] RAM_LO_A  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI_A  = ADDR_W'(RAM_BASE + RAM_BYTES);
  localparam logic [ADDR_W-1:0] REG_A     = ADDR_W'(REG_ADDR);
  localparam logic [RAM_AW-1:0] WIN_OFF_A = RAM_AW'(WIN_OFF);

  logic [PG_W-1:0]     page;
  logic [NUM_BLKS-1:0] blk_hit;
  logic                ovl_hit;

  assign page = addr[ADDR_W-1:BLK_W];

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
    assign blk_hit[g] = ovl_en && (ovl_sel == SEL_W'(g)) && (page == PG_W'(g));
  end

  assign ovl_hit = |blk_hit;

  always_comb begin
    tgt     = TGT_NONE;
    fl_addr = addr[FL_AW-1:0];
    rm_addr = RAM_AW'(addr - RAM_LO_A);
    if (req) begin
      if (ovl_hit) begin
        tgt     = TGT_RAM;
        rm_addr = WIN_OFF_A + RAM_AW'(addr[BLK_W-1:0]);
      end else if (addr < FL_END_A) begin
        tgt = TGT_FLASH;
      end else if (addr >= RAM_LO_A && addr < RAM_HI_A) begin
        tgt = TGT_RAM;
      end else if (addr == REG_A) begin
        tgt = TGT_REG;
      end
    end
  end

  assert_off_to_flash_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !ovl_en && addr < FL_END_A) |-> (tgt == TGT_FLASH && fl_addr == addr[FL_AW-1:0]))
    else $error("flash access misrouted with overlay off");

  assert_ovl_to_ram_R3: assert property (@(posedge clk) disable iff (rst)
    (req && ovl_en && page == PG_W'(ovl_sel)) |-> (tgt == TGT_RAM && rm_addr[BLK_W-1:0] == addr[BLK_W-1:0]))
    else $error("overlaid block not sent to RAM window");

  assert_high_flash_R5: assert property (@(posedge clk) disable iff (rst)
    (req && addr >= OVL_END_A && addr < FL_END_A) |-> (tgt == TGT_FLASH))
    else $error("non-overlayable flash block redirected");

  assert_ram_own_R6: assert property (@(posedge clk) disable iff (rst)
    (req && addr >= RAM_LO_A && addr < RAM_HI_A) |-> (tgt == TGT_RAM))
    else $error("RAM region not reachable at own address");
endmodule

// File: rtl/ovl_rdmux.sv
module ovl_rdmux
  import ovl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  tgt_e              rd_tgt,
  input  logic              reg_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic [DATA_W-1:0] rm_rdata,
  output logic [DATA_W-1:0] bus_rdata
);
  tgt_e           sel_q;
  logic [SEL_W:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= TGT_NONE;
      reg_q <= '0;
    end else begin
      sel_q <= rd_tgt;
      reg_q <= {reg_en, reg_sel};
    end
  end

  always_comb begin
    case (sel_q)
      TGT_FLASH: bus_rdata = fl_rdata;
      TGT_RAM:   bus_rdata = rm_rdata;
      TGT_REG:   bus_rdata = DATA_W'(reg_q);
      default:   bus_rdata = '0;
    endcase
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_tgt == TGT_NONE) |=> (bus_rdata == '0))
    else $error("read data not zero after idle or unmapped cycle");

  assert_reg_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_tgt == TGT_REG) |=> (bus_rdata == DATA_W'($past({reg_en, reg_sel}))))
    else $error("register read-back mismatch");

  assert_flash_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_tgt == TGT_FLASH) |=> (bus_rdata == fl_rdata))
    else $error("flash read data not steered");

  assert_ram_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_tgt == TGT_RAM) |=> (bus_rdata == rm_rdata))
    else $error("RAM read data not steered");
endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
  import ovl_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int BLK_W       = 12,
  parameter int NUM_BLKS    = 8,
  parameter int FLASH_BYTES = 32'h40000,
  parameter int RAM_BASE    = 32'hFF9000,
  parameter int RAM_BYTES   = 32'h3000,
  parameter int WIN_BASE    = 32'hFFA000,
  parameter int REG_ADDR    = 32'hFFFF00,
  localparam int FL_AW      = $clog2(FLASH_BYTES),
  localparam int RAM_AW     = $clog2(RAM_BYTES),
  localparam int SEL_W      = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fl_cs,
  output logic              fl_we,
  output logic [FL_AW-1:0]  fl_addr,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              rm_cs,
  output logic              rm_we,
  output logic [RAM_AW-1:0] rm_addr,
  input  logic [DATA_W-1:0] rm_rdata,
  output logic [DATA_W-1:0] mem_wdata
);
  tgt_e             tgt;
  tgt_e             rd_tgt;
  logic             ovl_en;
  logic [SEL_W-1:0] ovl_sel;
  logic             reg_wr;

  ovl_decode #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .NUM_BLKS(NUM_BLKS),
    .FLASH_BYTES(FLASH_BYTES), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
    .WIN_BASE(WIN_BASE), .REG_ADDR(REG_ADDR),
    .FL_AW(FL_AW), .RAM_AW(RAM_AW), .SEL_W(SEL_W)
  ) u_dec (
    .clk(clk), .rst(rst), .req(bus_req), .addr(bus_addr),
    .ovl_en(ovl_en), .ovl_sel(ovl_sel),
    .tgt(tgt), .fl_addr(fl_addr), .rm_addr(rm_addr)
  );

  assign reg_wr    = bus_we && (tgt == TGT_REG);
  assign fl_cs     = (tgt == TGT_FLASH);
  assign rm_cs     = (tgt == TGT_RAM);
  assign fl_we     = fl_cs && bus_we;
  assign rm_we     = rm_cs && bus_we;
  assign mem_wdata = bus_wdata;
  assign rd_tgt    = bus_we ? TGT_NONE : tgt;

  ovl_ctrl_reg #(.SEL_W(SEL_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wdata(bus_wdata[SEL_W:0]),
    .ovl_en(ovl_en), .ovl_sel(ovl_sel)
  );

  ovl_rdmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .rd_tgt(rd_tgt),
    .reg_en(ovl_en), .reg_sel(ovl_sel),
    .fl_rdata(fl_rdata), .rm_rdata(rm_rdata), .bus_rdata(bus_rdata)
  );

  assert_one_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_cs, rm_cs}))
    else $error("both chip selects active");

  assert_no_cs_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (!fl_cs && !rm_cs))
    else $error("chip select without request");

  assert_write_path_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> (fl_we == fl_cs && rm_we == rm_cs))
    else $error("write enable does not follow routing");
endmodule

// File: tb/tb_ovl_remap.sv
`timescale 1ns/1ps
module tb_ovl_remap;
  localparam int CYC = 20;
  localparam logic [23:0] REG_A = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fl_cs, fl_we, rm_cs, rm_we;
  logic [17:0] fl_addr;
  logic [13:0] rm_addr;
  logic [31:0] fl_rdata, rm_rdata, mem_wdata;

  always #(CYC/2) clk = ~clk;

  ovl_remap dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
    .rm_cs(rm_cs), .rm_we(rm_we), .rm_addr(rm_addr), .rm_rdata(rm_rdata),
    .mem_wdata(mem_wdata)
  );

  function automatic logic [31:0] fl_val(input logic [17:0] a);
    return {14'h2A5, a};
  endfunction
  function automatic logic [31:0] rm_val(input logic [13:0] a);
    return {18'h1B5A3, a};
  endfunction

  always @(posedge clk) begin
    fl_rdata <= fl_val(fl_addr);
    rm_rdata <= rm_val(rm_addr);
  end

  logic       sh_en;
  logic [2:0] sh_sel;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // target codes: 0 none, 1 flash, 2 RAM, 3 register
  function automatic void model(input logic [23:0] a, output int t,
                                output logic [17:0] fa, output logic [13:0] ra);
    fa = a[17:0];
    ra = 14'(a - 24'hFF9000);
    t  = 0;
    if (sh_en && a[23:12] == {9'b0, sh_sel}) begin
      t  = 2;
      ra = 14'h1000 + {2'b0, a[11:0]};
    end else if (a < 24'h040000) t = 1;
    else if (a >= 24'hFF9000 && a < 24'hFFC000) t = 2;
    else if (a == REG_A) t = 3;
  endfunction

  task automatic access(input logic [23:0] a, input logic we,
                        input logic [31:0] wd, input string tag);
    int t;
    logic [17:0] fa;
    logic [13:0] ra;
    logic [31:0] er;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    model(a, t, fa, ra);
    chk(tag, "chip selects", {30'b0, fl_cs, rm_cs}, {30'b0, t == 1, t == 2});
    if (t == 1) begin
      chk(tag, "flash addr", {14'b0, fl_addr}, {14'b0, fa});
      chk(tag, "flash we", {31'b0, fl_we}, {31'b0, we});
    end
    if (t == 2) begin
      chk(tag, "ram addr", {18'b0, rm_addr}, {18'b0, ra});
      chk(tag, "ram we", {31'b0, rm_we}, {31'b0, we});
    end
    if (we) chk(tag, "write data", mem_wdata, wd);
    er = 32'h0;
    if (!we) begin
      case (t)
        1: er = fl_val(fa);
        2: er = rm_val(ra);
        3: er = {28'b0, sh_en, sh_sel};
        default: er = 32'h0;
      endcase
    end
    @(posedge clk);
    if (t == 3 && we) begin
      sh_en  = wd[3];
      sh_sel = wd[2:0];
    end
    @(negedge clk);
    bus_req = 1'b0;
    chk(tag, "read data", bus_rdata, er);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    logic        we;
    logic [31:0] wd;
    void'($urandom(32'd7351));
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    sh_en = 1'b0; sh_sel = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk("R1", "idle chip selects", {30'b0, fl_cs, rm_cs}, 32'h0);
    chk("R1", "idle read data", bus_rdata, 32'h0);
    @(negedge clk);
    access(REG_A, 1'b0, 32'h0, "R1");
    access(24'h000123, 1'b0, 32'h0, "R2");
    access(24'h03FFFC, 1'b1, 32'hCAFE0001, "R2");
    // R11: enable block 0, next access already redirected
    access(REG_A, 1'b1, 32'h0000_0008, "R11");
    access(24'h000123, 1'b0, 32'h0, "R11");
    access(24'h000FFF, 1'b1, 32'h1234_5678, "R7");
    access(24'h001000, 1'b1, 32'h8765_4321, "R7");
    access(24'hFFA123, 1'b0, 32'h0, "R6");
    access(24'hFF9000, 1'b0, 32'h0, "R6");
    access(24'hFFBFFF, 1'b0, 32'h0, "R6");
    // R4: block 7, neighbours stay in flash
    access(REG_A, 1'b1, 32'h0000_000F, "R4");
    access(24'h007000, 1'b0, 32'h0, "R4");
    access(24'h006FFF, 1'b0, 32'h0, "R4");
    access(24'h000123, 1'b0, 32'h0, "R11");
    access(24'h008000, 1'b0, 32'h0, "R5");
    access(24'h03F000, 1'b1, 32'h5555_AAAA, "R5");
    access(REG_A, 1'b0, 32'h0, "R9");
    // R9: upper write bits ignored, enable cleared
    access(REG_A, 1'b1, 32'hFFFF_FFF2, "R9");
    access(REG_A, 1'b0, 32'h0, "R9");
    access(24'h002345, 1'b0, 32'h0, "R2");
    access(24'h500000, 1'b0, 32'h0, "R8");
    access(24'hFFFF04, 1'b1, 32'h0000_000F, "R8");
    access(REG_A, 1'b0, 32'h0, "R8");
    for (int i = 0; i < 600; i++) begin
      int cat;
      cat = int'($urandom_range(0, 9));
      we  = 1'($urandom_range(0, 1));
      wd  = $urandom;
      case (cat)
        0, 1, 2, 3: a = 24'($urandom_range(0, 32'h7FFF));
        4:          a = 24'($urandom_range(32'h8000, 32'h3FFFF));
        5, 6:       a = 24'($urandom_range(32'hFF9000, 32'hFFBFFF));
        7: begin a = REG_A; we = 1'b1; end
        8: begin a = REG_A; we = 1'b0; end
        default:    a = 24'($urandom_range(32'h40000, 32'hFF8FFF));
      endcase
      access(a, we, wd, "R10");
      if (cat == 9) begin
        @(negedge clk);
        chk("R8", "idle read data", bus_rdata, 32'h0);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule